// File: doc/BRIEF.md
# PCIe Local Interrupt Mask and Status Unit

This unit gathers the four legacy INTx wires (INTA through INTD) and one MSI event line of a PCIe root-port controller into a sticky local status word. A separate local mask word selects which of those pending events may reach the host. One combined interrupt line goes to the host's interrupt controller. A per-pin pending vector lets the service routine dispatch INTA to INTD one by one without decoding the status word itself.

Software uses a plain 32-bit register port. Both words keep their five event bits in the same field. Pin n (INTA = 0 up to INTD = 3) owns bit 24+n and the MSI event owns bit 28.

The port has no valid/ready handshake, because nothing on it can stall. A write completes at the clock edge where `reg_we_i` is high. Read data is a combinational function of `reg_addr_i` and the current register contents. An access may therefore be issued on every cycle without back-pressure.

The usual service sequence is:

1. Read the status word. A value of zero means nothing is pending.
2. Handle the bits that are set.
3. Write the same value back to the status word to acknowledge those bits.

Each source is level- or edge-sensitive, chosen per source by a parameter. By default INTx sources are level-sensitive and the MSI source is edge-sensitive.

Top module: `lirq_unit`

## Requirements
- R1: While `rst_ni` is low, and after it is released until the first write, the mask word and the status word are zero, `irq_o` is low and `intx_pend_o` is zero.
- R2: The mask word sits at byte address 0x180. A write there stores `reg_wdata_i[28:24]` into the mask at the next edge. Bits 24 to 27 are INTA to INTD and bit 28 is MSI. All other bits of the word read as zero and ignore written data.
- R3: The status word sits at byte address 0x184 and uses the same bit positions as the mask. An asserted source sets its bit at the next clock edge. The bit stays set after the source drops, until software clears it.
- R4: A write to the status word clears exactly the bits written as one and leaves the bits written as zero untouched. A full-word write of all ones (0xFFFFFFFF) is accepted and clears every bit.
- R5: When a set event and a clear write hit the same status bit at the same edge, the bit ends up set.
- R6: A level-sensitive source (default: all four INTx pins) sets its bit at every edge where it is high. Clearing the bit while the pin stays high therefore leaves it set.
- R7: An edge-sensitive source (default: MSI) sets its bit only at an edge where it is high after being low at the previous edge. A source held high does not set the bit again once it is cleared. A source already high when reset is released counts as one rising edge.
- R8: `irq_o` is high exactly when some bit is set in both the status word and the mask word. It follows the registers with no further register stage.
- R9: `intx_pend_o[n]` is high exactly when status bit 24+n and mask bit 24+n are both set, for n = 0..3.
- R10: Reads from any address other than 0x180 or 0x184 return zero. Writes to any other address change neither word, including unaligned offsets such as 0x181.
- R11: The port accepts one access per cycle with no stall. An arbitrary mix of writes, reads and source activity on consecutive cycles keeps the read data, `irq_o` and `intx_pend_o` consistent with R2 to R10 at every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | 12 | Byte address of the access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| intx_i | input | 4 | Legacy interrupt inputs, bit n = INTA+n |
| msi_i | input | 1 | MSI event input |
| irq_o | output | 1 | Combined masked interrupt to the host |
| intx_pend_o | output | 4 | Per-pin masked pending INTx flags |

## Verification
The bench builds the unit with its default parameters: 12-bit byte addresses, the field starting at bit 24, and the two words at 0x180 and 0x184. With those defaults INTx is level-sensitive and MSI is edge-sensitive, so one build exercises both source flavours. The cases covered include:

- a clear write that lands while a pin is still held high;
- an MSI line that never drops;
- a simultaneous set and clear;
- unaligned and foreign addresses.

A random phase then mixes writes to both words and to other addresses with random source activity on consecutive cycles.

// File: rtl/lirq_pkg.sv
package lirq_pkg;

  typedef enum logic {
    SENSE_LEVEL = 1'b0,
    SENSE_EDGE  = 1'b1
  } sense_e;

  // Place a narrow event vector into a full data word at a given offset.
  function automatic logic [31:0] place_field(input logic [7:0] bits, input int lsb, input int width);
    logic [31:0] w;
    w = '0;
    for (int i = 0; i < width; i++) begin
      w[lsb + i] = bits[i];
    end
    return w;
  endfunction

endpackage

// File: rtl/lirq_src_cell.sv
module lirq_src_cell
  import lirq_pkg::*;
#(
  parameter sense_e SENSE = SENSE_LEVEL
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic clr_i,
  output logic stat_o
);

  logic set_w;
  logic stat_q;

  generate
    if (SENSE == SENSE_EDGE) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= src_i;
      end
      assign set_w = src_i & ~prev_q;
    end else begin : g_level
      assign set_w = src_i;
    end
  endgenerate

  // A set event takes priority over a clear in the same cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stat_q <= 1'b0;
    else if (set_w) stat_q <= 1'b1;
    else if (clr_i) stat_q <= 1'b0;
  end

  assign stat_o = stat_q;

endmodule

// File: rtl/lirq_decode.sv
module lirq_decode #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int N_SRC     = 5,
  parameter int FIELD_LSB = 24,
  parameter logic [ADDR_W-1:0] MASK_OFS = 12'h180,
  parameter logic [ADDR_W-1:0] STAT_OFS = 12'h184
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              sel_mask_o,
  output logic              sel_stat_o,
  output logic              mask_wr_o,
  output logic [N_SRC-1:0]  wfield_o,
  output logic [N_SRC-1:0]  clr_vec_o
);

  logic unused_wbits;

  assign sel_mask_o = (addr_i == MASK_OFS);
  assign sel_stat_o = (addr_i == STAT_OFS);
  assign mask_wr_o  = we_i & sel_mask_o;
  assign wfield_o   = wdata_i[FIELD_LSB +: N_SRC];
  assign clr_vec_o  = (we_i & sel_stat_o) ? wfield_o : '0;

  // Reserved bit positions carry no meaning on writes.
  assign unused_wbits = ^{wdata_i[DATA_W-1:FIELD_LSB+N_SRC], wdata_i[FIELD_LSB-1:0]};

endmodule

// File: rtl/lirq_mask_reg.sv
module lirq_mask_reg #(
  parameter int N_SRC = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [N_SRC-1:0] d_i,
  output logic [N_SRC-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= d_i;
  end

endmodule

// File: rtl/lirq_readback.sv
module lirq_readback #(
  parameter int DATA_W    = 32,
  parameter int N_SRC     = 5,
  parameter int FIELD_LSB = 24
) (
  input  logic              sel_mask_i,
  input  logic              sel_stat_i,
  input  logic [N_SRC-1:0]  mask_i,
  input  logic [N_SRC-1:0]  stat_i,
  output logic [DATA_W-1:0] rdata_o
);

  always_comb begin
    rdata_o = '0;
    if (sel_mask_i)      rdata_o[FIELD_LSB +: N_SRC] = mask_i;
    else if (sel_stat_i) rdata_o[FIELD_LSB +: N_SRC] = stat_i;
  end

endmodule

// File: rtl/lirq_unit.sv
module lirq_unit
  import lirq_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int N_INTX    = 4,
  parameter int FIELD_LSB = 24,
  parameter logic [ADDR_W-1:0] MASK_OFS = 12'h180,
  parameter logic [ADDR_W-1:0] STAT_OFS = 12'h184,
  // One bit per source, INTx pins first, MSI last; 1 = edge-sensitive.
  parameter logic [N_INTX:0] SRC_EDGE = 5'b10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [N_INTX-1:0] intx_i,
  input  logic              msi_i,
  output logic              irq_o,
  output logic [N_INTX-1:0] intx_pend_o
);

  localparam int N_SRC = N_INTX + 1;

  logic [N_SRC-1:0] src_vec;
  logic [N_SRC-1:0] stat_q;
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] clr_vec;
  logic [N_SRC-1:0] wfield;
  logic [N_SRC-1:0] live;
  logic             sel_mask;
  logic             sel_stat;
  logic             mask_wr;

  assign src_vec = {msi_i, intx_i};

  lirq_decode #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .N_SRC    (N_SRC),
    .FIELD_LSB(FIELD_LSB),
    .MASK_OFS (MASK_OFS),
    .STAT_OFS (STAT_OFS)
  ) u_dec (
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .sel_mask_o(sel_mask),
    .sel_stat_o(sel_stat),
    .mask_wr_o (mask_wr),
    .wfield_o  (wfield),
    .clr_vec_o (clr_vec)
  );

  lirq_mask_reg #(.N_SRC(N_SRC)) u_mask (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (mask_wr),
    .d_i   (wfield),
    .q_o   (mask_q)
  );

  generate
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
      lirq_src_cell #(
        .SENSE(SRC_EDGE[s] ? SENSE_EDGE : SENSE_LEVEL)
      ) u_cell (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .src_i (src_vec[s]),
        .clr_i (clr_vec[s]),
        .stat_o(stat_q[s])
      );
    end
  endgenerate

  lirq_readback #(
    .DATA_W   (DATA_W),
    .N_SRC    (N_SRC),
    .FIELD_LSB(FIELD_LSB)
  ) u_rb (
    .sel_mask_i(sel_mask),
    .sel_stat_i(sel_stat),
    .mask_i    (mask_q),
    .stat_i    (stat_q),
    .rdata_o   (reg_rdata_o)
  );

  assign live        = stat_q & mask_q;
  assign irq_o       = |live;
  assign intx_pend_o = live[N_INTX-1:0];

endmodule

// File: rtl/lirq_unit_chk.sv
module lirq_unit_chk #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int N_INTX    = 4,
  parameter int FIELD_LSB = 24,
  parameter logic [ADDR_W-1:0] MASK_OFS = 12'h180,
  parameter logic [ADDR_W-1:0] STAT_OFS = 12'h184,
  parameter logic [N_INTX:0] SRC_EDGE = 5'b10000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic [N_INTX-1:0] intx_i,
  input logic              msi_i,
  input logic              irq_o,
  input logic [N_INTX-1:0] intx_pend_o,
  input logic [N_INTX:0]   stat_q,
  input logic [N_INTX:0]   mask_q
);

  localparam int N_SRC = N_INTX + 1;
  localparam logic [DATA_W-1:0] FIELD_MASK = {{(DATA_W-N_SRC){1'b0}}, {N_SRC{1'b1}}} << FIELD_LSB;
  localparam logic [N_SRC-1:0] LEVEL_SEL = ~SRC_EDGE;

  logic [N_SRC-1:0] src_w;
  logic [N_SRC-1:0] wr_field;
  logic [N_SRC-1:0] clr_w;
  logic             mask_hit;

  assign src_w    = {msi_i, intx_i};
  assign wr_field = reg_wdata_i[FIELD_LSB +: N_SRC];
  assign mask_hit = reg_we_i && (reg_addr_i == MASK_OFS);
  assign clr_w    = (reg_we_i && (reg_addr_i == STAT_OFS)) ? wr_field : '0;

  // R3: a set bit only drops where a clear was written
  assert_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(stat_q) & ~$past(clr_w) & ~stat_q) == '0));

  // R3: a bit never rises without its source
  assert_no_spurious_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & ~$past(stat_q) & ~$past(src_w)) == '0));

  // R5, R6: a high level source always leaves its bit set
  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(src_w) & LEVEL_SEL & ~stat_q) == '0));

  // R2: mask write takes the field
  assert_mask_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_hit |=> (mask_q == $past(wr_field)));

  // R2: reserved bits read zero
  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((reg_rdata_o & ~FIELD_MASK) == '0));

  // R8: output only with a live masked event
  assert_irq_needs_event_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((stat_q & mask_q) != '0));

  // R9: pending flags never exceed the mask
  assert_pend_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((intx_pend_o & ~mask_q[N_INTX-1:0]) == '0));

  // R10: foreign writes leave the mask alone
  assert_foreign_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && (reg_addr_i != MASK_OFS)) |=> $stable(mask_q));

endmodule

bind lirq_unit lirq_unit_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .N_INTX   (N_INTX),
  .FIELD_LSB(FIELD_LSB),
  .MASK_OFS (MASK_OFS),
  .STAT_OFS (STAT_OFS),
  .SRC_EDGE (SRC_EDGE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .intx_i     (intx_i),
  .msi_i      (msi_i),
  .irq_o      (irq_o),
  .intx_pend_o(intx_pend_o),
  .stat_q     (stat_q),
  .mask_q     (mask_q)
);

// File: tb/lirq_unit_tb_top.sv
`timescale 1ns/1ps
module lirq_unit_tb_top;

  localparam logic [11:0] A_MASK = 12'h180;
  localparam logic [11:0] A_STAT = 12'h184;
  localparam logic [4:0]  EDGE_SEL = 5'b10000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  intx = '0;
  logic        msi = 1'b0;
  logic        irq;
  logic [3:0]  pend;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  int unsigned cyc = 0;
  bit          done = 1'b0;
  string       cur_req = "R1";

  // behavioural reference state
  logic [4:0] m_stat = '0;
  logic [4:0] m_mask = '0;
  logic [4:0] m_prev = '0;

  always #4 clk = ~clk;

  lirq_unit #(.SRC_EDGE(EDGE_SEL)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .reg_we_i   (we),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .intx_i     (intx),
    .msi_i      (msi),
    .irq_o      (irq),
    .intx_pend_o(pend)
  );

  always @(posedge clk) begin
    logic [4:0] src, setv, clrv;
    if (!rst_n) begin
      m_stat = '0; m_mask = '0; m_prev = '0;
    end else begin
      src  = {msi, intx};
      setv = 5'b0;
      for (int i = 0; i < 5; i++)
        setv[i] = EDGE_SEL[i] ? (src[i] && !m_prev[i]) : src[i];
      clrv = (we && addr == A_STAT) ? wdata[28:24] : 5'b0;
      m_stat = (m_stat & ~clrv) | setv;
      if (we && addr == A_MASK) m_mask = wdata[28:24];
      m_prev = src;
    end
  end

  task automatic check32(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at cycle %0d", cur_req, what, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    logic [31:0] e_rd;
    e_rd = 32'h0;
    if (addr == A_MASK)      e_rd[28:24] = m_mask;
    else if (addr == A_STAT) e_rd[28:24] = m_stat;
    check32(rdata, e_rd, "rdata");
    check32({31'b0, irq}, {31'b0, |(m_stat & m_mask)}, "irq");
    check32({28'b0, pend}, {28'b0, m_stat[3:0] & m_mask[3:0]}, "pend");
  endtask

  task automatic step(input logic w, input logic [11:0] a, input logic [31:0] d,
                      input logic [3:0] ix, input logic m);
    @(negedge clk);
    we = w; addr = a; wdata = d; intx = ix; msi = m;
    #1;
    compare_all();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    step(0, A_MASK, 0, 4'h0, 0);
    step(0, A_STAT, 0, 4'h0, 0);
    rst_n = 1'b1;
    step(0, A_STAT, 0, 4'h0, 0);
    step(0, A_MASK, 0, 4'h0, 0);

    // R2: mask field, reserved bits
    cur_req = "R2";
    step(1, A_MASK, 32'hFFFF_FFFF, 4'h0, 0);
    step(0, A_MASK, 0, 4'h0, 0);
    step(1, A_MASK, 32'h0A00_0000, 4'h0, 0);
    step(0, A_MASK, 0, 4'h0, 0);
    step(1, A_MASK, 32'hE0FF_FFFF, 4'h0, 0);
    step(0, A_MASK, 0, 4'h0, 0);

    // R3: sticky after source drops
    cur_req = "R3";
    step(0, A_STAT, 0, 4'b0010, 0);
    step(0, A_STAT, 0, 4'b0000, 0);
    step(0, A_STAT, 0, 4'b0000, 0);
    step(0, A_STAT, 0, 4'b0000, 0);

    // R4: selective and full-word clear
    cur_req = "R4";
    step(0, A_STAT, 0, 4'b1111, 1);
    step(0, A_STAT, 0, 4'b0000, 0);
    step(1, A_STAT, 32'h0500_0000, 4'h0, 0);
    step(0, A_STAT, 0, 4'h0, 0);
    step(1, A_STAT, 32'hFFFF_FFFF, 4'h0, 0);
    step(0, A_STAT, 0, 4'h0, 0);

    // R5 / R6: clear while a level pin is high
    cur_req = "R5";
    step(0, A_STAT, 0, 4'b0100, 0);
    step(1, A_STAT, 32'h0400_0000, 4'b0100, 0);
    step(0, A_STAT, 0, 4'b0100, 0);
    cur_req = "R6";
    step(1, A_STAT, 32'h0400_0000, 4'b0100, 0);
    step(0, A_STAT, 0, 4'b0000, 0);
    step(1, A_STAT, 32'h0400_0000, 4'b0000, 0);
    step(0, A_STAT, 0, 4'b0000, 0);

    // R7: edge-sensitive MSI held high
    cur_req = "R7";
    step(0, A_STAT, 0, 4'h0, 1);
    step(0, A_STAT, 0, 4'h0, 1);
    step(1, A_STAT, 32'h1000_0000, 4'h0, 1);
    step(0, A_STAT, 0, 4'h0, 1);
    step(0, A_STAT, 0, 4'h0, 1);
    step(0, A_STAT, 0, 4'h0, 0);
    step(0, A_STAT, 0, 4'h0, 1);
    step(1, A_STAT, 32'hFFFF_FFFF, 4'h0, 0);

    // R8 / R9: masking of the output and per-pin flags
    cur_req = "R8";
    step(1, A_MASK, 32'h0300_0000, 4'b0101, 0);
    step(0, A_STAT, 0, 4'b0000, 0);
    step(0, A_MASK, 0, 4'b0000, 0);
    cur_req = "R9";
    step(1, A_MASK, 32'h1F00_0000, 4'b0000, 0);
    step(0, A_STAT, 0, 4'b0000, 0);
    step(1, A_MASK, 32'h0000_0000, 4'b0000, 0);
    step(0, A_STAT, 0, 4'b0000, 0);
    step(1, A_STAT, 32'hFFFF_FFFF, 4'b0000, 0);

    // R10: foreign and unaligned addresses
    cur_req = "R10";
    step(0, A_STAT, 0, 4'b1000, 0);
    step(1, 12'h188, 32'hFFFF_FFFF, 4'b0000, 0);
    step(1, 12'h181, 32'hFFFF_FFFF, 4'b0000, 0);
    step(1, 12'h185, 32'hFFFF_FFFF, 4'b0000, 0);
    step(0, 12'h188, 0, 4'b0000, 0);
    step(0, 12'h000, 0, 4'b0000, 0);
    step(0, A_STAT, 0, 4'b0000, 0);
    step(0, A_MASK, 0, 4'b0000, 0);

    // R11: back-to-back random traffic
    cur_req = "R11";
    for (int k = 0; k < 600; k++) begin
      logic [11:0] ra;
      logic [31:0] rd;
      case ($urandom_range(0, 3))
        0: ra = A_MASK;
        1: ra = A_STAT;
        2: ra = 12'h188;
        default: ra = 12'h184 ^ 12'($urandom_range(1, 15));
      endcase
      rd = $urandom();
      step(1'($urandom_range(0, 1)), ra, rd, 4'($urandom_range(0, 15)),
           ($urandom_range(0, 3) == 0));
    end

    step(0, A_STAT, 0, 4'h0, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule